// File: doc/BRIEF.md
# Control sequencer with counters

This block is a small control engine that steps through a program of 64-bit instruction slots held in an external instruction memory. The low byte of each slot is the header: bits [6:0] select the operation and bit 7 is a phase flag that does not change execution. The sequencer issues byte and word writes on a simple register bus, pauses for a programmed number of cycles or until external agents raise event flags, branches on events or on loop counters, and finally raises a one-cycle notify and stops. Any opcode outside its fixed table stops it with a fault flag.

It keeps 16 address registers (32 bits each), 16 loop counters whose value is limited to 2^CNT_LOG2 (2^24 by default), and 128 event flags. An event flag is set by a one-cycle pulse on its bit of `ev_set` and stays set until the program clears it. Fields after the header are laid out as: bits [15:8] `sel` (register, counter or event index, or a data byte), bits [31:16] `tgt` (absolute branch target), bits [63:32] `imm` (32-bit immediate).

The controller is a state machine with six states. FETCH requests the slot at the program counter; EXEC executes the slot returned one cycle later and normally goes back to FETCH with the counter advanced by one. EXEC goes to WCYC for a nonzero cycle wait, to WEV when an event wait is not yet met, to HALT on the notify-and-stop opcode and to FAULT on an undefined opcode. WCYC returns to FETCH when its count runs out, WEV returns to FETCH when its events are present, and HALT and FAULT are kept until reset.

Top module: `ctl_seq`

## Requirements
- R1: After reset the program counter is 0, `imem_rd` is high with `imem_addr` = 0, and `halted`, `fault`, `notify` and `wr_en` are low; the instruction memory returns data one cycle after `imem_rd`.
- R2: The opcode is header bits [6:0]; header bit 7 (phase) has no effect on any operation.
- R3: Opcode 0x60 loads address register `sel[3:0]` with `imm`; opcode 0x04 writes `imm[7:0]` (zero-extended, `wr_wide`=0) and opcode 0x05 writes `imm` (`wr_wide`=1), both to the address held in register `sel[3:0]`.
- R4: Opcode 0x08 writes the byte `sel` (zero-extended, `wr_wide`=0) to the address `imm`.
- R5: Opcode 0x10 raises `notify` for exactly one cycle and then `halted` stays high with no further fetch or write until reset.
- R6: Opcode 0x20 waits `imm` cycles: a write placed before it and one placed after it are `imm`+4 cycles apart (4 when `imm` is 0).
- R7: Opcode 0x24 waits until event `sel[6:0]` is set; opcode 0x25 waits until every event whose bit is set in `imm` within the 32-event group `sel[1:0]` (events 32·`sel[1:0]` + bit) is set; flags already set let the program pass at once.
- R8: Opcode 0x30 jumps to slot `tgt`; opcode 0x34 jumps to `tgt` when event `sel[6:0]` is set and otherwise falls through to the next slot.
- R9: Opcode 0x40 loads counter `sel[3:0]` with `imm`, saturated to 2^CNT_LOG2; opcode 0x38 jumps to `tgt` when that counter is zero and opcode 0x39 when it is nonzero.
- R10: Opcode 0x41 decrements counter `sel[3:0]` by one, and leaves a zero counter at zero.
- R11: Opcode 0x51 clears event `sel[6:0]` and opcode 0x50 clears all events; a set pulse in the same cycle as a clear wins.
- R12: Any other opcode raises `fault` and `halted`, issues no write and no notify, and holds `imem_addr` at the faulting slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| imem_rd | output | 1 | Instruction fetch request |
| imem_addr | output | PC_W | Slot index to fetch |
| imem_rdata | input | 64 | Slot returned one cycle after the request |
| ev_set | input | N_EV | One-cycle pulses that set event flags |
| wr_en | output | 1 | Register bus write strobe |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Write data |
| wr_wide | output | 1 | 1 = 32-bit write, 0 = 8-bit write |
| notify | output | 1 | One-cycle pulse when the program stops normally |
| halted | output | 1 | Sequencer stopped (normal or fault) |
| fault | output | 1 | Sequencer stopped on an undefined opcode |

## Verification
Assertions watch on every cycle that counters never exceed their ceiling, that a decrement of a zero counter keeps it at zero, that a set pulse always leaves its event flag raised, that a notify is followed by a sticky stop without writes, that a fault freezes the fetch address, and that fetches are never back to back. Only the bench scenarios can show the operand decoding of each write form, the exact cycle distance produced by a timed wait, the blocking of event waits until the right pulses arrive, branch selection through taken and untaken paths, loop counts including a saturated load, and the silent stop on an unknown opcode.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;

    typedef enum logic [6:0] {
        OP_WR8_IND   = 7'h04,
        OP_WR32_IND  = 7'h05,
        OP_WR8_DIR   = 7'h08,
        OP_NOTE_STOP = 7'h10,
        OP_WAIT_CYC  = 7'h20,
        OP_WAIT_EV   = 7'h24,
        OP_WAIT_EVM  = 7'h25,
        OP_JMP       = 7'h30,
        OP_JMP_EV    = 7'h34,
        OP_JMP_CZ    = 7'h38,
        OP_JMP_CNZ   = 7'h39,
        OP_CNT_LOAD  = 7'h40,
        OP_CNT_DEC   = 7'h41,
        OP_EV_CLRALL = 7'h50,
        OP_EV_CLR    = 7'h51,
        OP_AR_LOAD   = 7'h60
    } op_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_EXEC,
        ST_WCYC,
        ST_WEV,
        ST_HALT,
        ST_FAULT
    } st_e;

    typedef struct packed {
        logic [31:0] imm;
        logic [15:0] tgt;
        logic [7:0]  sel;
        logic        phase;
        logic [6:0]  op;
    } slot_t;

endpackage

// File: rtl/ctl_seq_evbank.sv
module ctl_seq_evbank #(
    parameter int N_EV = 128
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_EV-1:0]         ext_set,
    input  logic                    clr_all,
    input  logic                    clr_one,
    input  logic [$clog2(N_EV)-1:0] clr_idx,
    output logic [N_EV-1:0]         flags
);
    localparam int IW = $clog2(N_EV);

    for (genvar g = 0; g < N_EV; g++) begin : g_ev
        logic q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= 1'b0;
            else if (ext_set[g])
                q <= 1'b1;
            else if (clr_all || (clr_one && clr_idx == IW'(g)))
                q <= 1'b0;
        end
        assign flags[g] = q;

        assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
            ext_set[g] |=> flags[g]);
    end
endmodule

// File: rtl/ctl_seq_cntbank.sv
module ctl_seq_cntbank #(
    parameter int N_CNT    = 16,
    parameter int CNT_LOG2 = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     set_en,
    input  logic                     dec_en,
    input  logic [$clog2(N_CNT)-1:0] idx,
    input  logic [31:0]              set_val,
    output logic                     zero
);
    localparam int CW = CNT_LOG2 + 1;
    localparam int IW = $clog2(N_CNT);
    localparam logic [32:0]   LIM33 = 33'd1 << CNT_LOG2;
    localparam logic [CW-1:0] LIM   = LIM33[CW-1:0];

    logic [CW-1:0] cnt [N_CNT];
    logic [CW-1:0] sat_val;

    always_comb sat_val = ({1'b0, set_val} > LIM33) ? LIM : set_val[CW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_CNT; i++) cnt[i] <= '0;
        end else if (set_en) begin
            cnt[idx] <= sat_val;
        end else if (dec_en && cnt[idx] != '0) begin
            cnt[idx] <= cnt[idx] - 1'b1;
        end
    end

    assign zero = (cnt[idx] == '0);

    for (genvar g = 0; g < N_CNT; g++) begin : g_chk
        assert_cnt_ceiling_R9: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[g] <= LIM);
        assert_dec_floor_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_en && !set_en && idx == IW'(g) && cnt[g] == '0) |=> cnt[g] == '0);
    end
endmodule

// File: rtl/ctl_seq_arbank.sv
module ctl_seq_arbank #(
    parameter int N_AR = 16,
    parameter int AW   = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [$clog2(N_AR)-1:0] idx,
    input  logic [AW-1:0]           wr_val,
    output logic [AW-1:0]           rd_val
);
    logic [AW-1:0] ar [N_AR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_AR; i++) ar[i] <= '0;
        end else if (wr_en) begin
            ar[idx] <= wr_val;
        end
    end

    assign rd_val = ar[idx];
endmodule

// File: rtl/ctl_seq.sv
module ctl_seq
    import ctl_seq_pkg::*;
#(
    parameter int PC_W     = 16,
    parameter int N_AR     = 16,
    parameter int N_CNT    = 16,
    parameter int N_EV     = 128,
    parameter int CNT_LOG2 = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic            imem_rd,
    output logic [PC_W-1:0] imem_addr,
    input  logic [63:0]     imem_rdata,
    input  logic [N_EV-1:0] ev_set,
    output logic            wr_en,
    output logic [31:0]     wr_addr,
    output logic [31:0]     wr_data,
    output logic            wr_wide,
    output logic            notify,
    output logic            halted,
    output logic            fault
);
    localparam int EVW = $clog2(N_EV);
    localparam int CIW = $clog2(N_CNT);
    localparam int AIW = $clog2(N_AR);
    localparam int GW  = (N_EV > 32) ? $clog2(N_EV / 32) : 1;

    st_e             st, st_nx;
    logic [PC_W-1:0] pc, pc_nx;
    slot_t           ir, cur, src;
    logic [31:0]     wcnt;

    logic            ev_clr_all, ev_clr_one, cnt_set, cnt_dec, ar_wr;
    logic [N_EV-1:0] flags, grp_bits;
    logic            ev_one, ev_all, cnt_zero;
    logic [31:0]     ar_val;

    assign cur = slot_t'(imem_rdata);
    assign src = (st == ST_EXEC) ? cur : ir;

    ctl_seq_evbank #(.N_EV(N_EV)) u_ev (
        .clk(clk), .rst_n(rst_n), .ext_set(ev_set), .clr_all(ev_clr_all),
        .clr_one(ev_clr_one), .clr_idx(cur.sel[EVW-1:0]), .flags(flags)
    );

    ctl_seq_cntbank #(.N_CNT(N_CNT), .CNT_LOG2(CNT_LOG2)) u_cnt (
        .clk(clk), .rst_n(rst_n), .set_en(cnt_set), .dec_en(cnt_dec),
        .idx(cur.sel[CIW-1:0]), .set_val(cur.imm), .zero(cnt_zero)
    );

    ctl_seq_arbank #(.N_AR(N_AR), .AW(32)) u_ar (
        .clk(clk), .rst_n(rst_n), .wr_en(ar_wr), .idx(cur.sel[AIW-1:0]),
        .wr_val(cur.imm), .rd_val(ar_val)
    );

    // event conditions for the slot in EXEC or the latched slot in WEV
    assign ev_one   = flags[src.sel[EVW-1:0]];
    assign grp_bits = flags >> {src.sel[GW-1:0], 5'b0};
    assign ev_all   = ((grp_bits[31:0] & src.imm) == src.imm);

    // next-state and control decode
    always_comb begin
        st_nx      = st;
        pc_nx      = pc;
        ev_clr_all = 1'b0;
        ev_clr_one = 1'b0;
        cnt_set    = 1'b0;
        cnt_dec    = 1'b0;
        ar_wr      = 1'b0;
        unique case (st)
            ST_FETCH: st_nx = ST_EXEC;
            ST_EXEC: begin
                st_nx = ST_FETCH;
                pc_nx = pc + 1'b1;
                case (cur.op)
                    OP_WR8_IND, OP_WR32_IND, OP_WR8_DIR: ;
                    OP_NOTE_STOP: st_nx = ST_HALT;
                    OP_WAIT_CYC:  if (cur.imm != '0) st_nx = ST_WCYC;
                    OP_WAIT_EV:   if (!ev_one) st_nx = ST_WEV;
                    OP_WAIT_EVM:  if (!ev_all) st_nx = ST_WEV;
                    OP_JMP:       pc_nx = PC_W'(cur.tgt);
                    OP_JMP_EV:    if (ev_one) pc_nx = PC_W'(cur.tgt);
                    OP_JMP_CZ:    if (cnt_zero) pc_nx = PC_W'(cur.tgt);
                    OP_JMP_CNZ:   if (!cnt_zero) pc_nx = PC_W'(cur.tgt);
                    OP_CNT_LOAD:  cnt_set = 1'b1;
                    OP_CNT_DEC:   cnt_dec = 1'b1;
                    OP_EV_CLRALL: ev_clr_all = 1'b1;
                    OP_EV_CLR:    ev_clr_one = 1'b1;
                    OP_AR_LOAD:   ar_wr = 1'b1;
                    default: begin
                        st_nx = ST_FAULT;
                        pc_nx = pc;
                    end
                endcase
            end
            ST_WCYC:  if (wcnt == 32'd1) st_nx = ST_FETCH;
            ST_WEV:   if ((ir.op == OP_WAIT_EV) ? ev_one : ev_all) st_nx = ST_FETCH;
            ST_HALT:  st_nx = ST_HALT;
            ST_FAULT: st_nx = ST_FAULT;
            default:  st_nx = ST_FAULT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= ST_FETCH;
            pc   <= '0;
            ir   <= '0;
            wcnt <= '0;
        end else begin
            st <= st_nx;
            pc <= pc_nx;
            if (st == ST_EXEC) begin
                ir   <= cur;
                wcnt <= cur.imm;
            end else if (st == ST_WCYC) begin
                wcnt <= wcnt - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        imem_rd   = (st == ST_FETCH);
        imem_addr = pc;
        wr_en     = 1'b0;
        wr_wide   = 1'b0;
        wr_addr   = ar_val;
        wr_data   = {24'b0, cur.imm[7:0]};
        notify    = 1'b0;
        if (st == ST_EXEC) begin
            case (cur.op)
                OP_WR8_IND:   wr_en = 1'b1;
                OP_WR32_IND: begin
                    wr_en   = 1'b1;
                    wr_wide = 1'b1;
                    wr_data = cur.imm;
                end
                OP_WR8_DIR: begin
                    wr_en   = 1'b1;
                    wr_addr = cur.imm;
                    wr_data = {24'b0, cur.sel};
                end
                OP_NOTE_STOP: notify = 1'b1;
                default: ;
            endcase
        end
        halted = (st == ST_HALT) || (st == ST_FAULT);
        fault  = (st == ST_FAULT);
    end

    assert_notify_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        notify |=> halted && !notify);
    assert_stop_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted && !wr_en && !imem_rd);
    assert_fault_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault && $stable(imem_addr));
    assert_fetch_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        imem_rd |=> !imem_rd);
endmodule

// File: tb/sim_ctl_seq.sv
module sim_ctl_seq;
    localparam int CNT_LOG2 = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         imem_rd;
    logic [15:0]  imem_addr;
    logic [63:0]  imem_rdata = '0;
    logic [127:0] ev_set = '0;
    logic         wr_en, wr_wide, notify, halted, fault;
    logic [31:0]  wr_addr, wr_data;

    always #5 clk = ~clk;

    ctl_seq #(.CNT_LOG2(CNT_LOG2)) u0 (
        .clk(clk), .rst_n(rst_n), .imem_rd(imem_rd), .imem_addr(imem_addr),
        .imem_rdata(imem_rdata), .ev_set(ev_set), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_wide(wr_wide), .notify(notify), .halted(halted),
        .fault(fault)
    );

    logic [63:0] mem [64];
    always_ff @(posedge clk) if (imem_rd) imem_rdata <= mem[imem_addr[5:0]];

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int          nl, nnote, nchk, nfail;
    logic [31:0] la [64];
    logic [31:0] ld [64];
    logic        lw [64];
    int          lc [64];
    initial begin nl = 0; nnote = 0; nchk = 0; nfail = 0; end

    always @(negedge clk) begin
        if (rst_n && wr_en && nl < 64) begin
            la[nl] = wr_addr; ld[nl] = wr_data; lw[nl] = wr_wide; lc[nl] = cyc;
            nl = nl + 1;
        end
        if (rst_n && notify) nnote = nnote + 1;
    end

    function automatic logic [63:0] ins(input logic [6:0] op, input logic [7:0] sel,
                                        input logic [15:0] tgt, input logic [31:0] imm,
                                        input logic ph = 1'b0);
        return {imm, tgt, sel, ph, op};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = ins(7'h10, 8'h0, 16'h0, 32'h0);
    endtask

    task automatic start(input logic [127:0] pre_ev);
        rst_n = 1'b0;
        ev_set = pre_ev;
        repeat (2) @(negedge clk);
        nl = 0; nnote = 0;
        rst_n = 1'b1;
        @(negedge clk);
        ev_set = '0;
    endtask

    task automatic wait_halt();
        for (int i = 0; i < 3000; i++) begin
            if (halted) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        clear_mem();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 halted in reset", halted, 0);
        chk("R1 fault in reset", fault, 0);
        chk("R1 wr_en in reset", wr_en, 0);
        chk("R1 notify in reset", notify, 0);
        chk("R1 first fetch addr", imem_addr, 0);
        chk("R1 first fetch rd", imem_rd, 1);
        start('0);
        wait_halt();
        chk("R5 notify count", nnote, 1);
        chk("R5 halted", halted, 1);
        repeat (5) @(negedge clk);
        chk("R5 stays halted", halted, 1);
        chk("R5 single notify", nnote, 1);
        chk("R5 no writes", nl, 0);
    endtask

    task automatic t_writes();
        clear_mem();
        mem[0] = ins(7'h60, 8'h03, 16'h0, 32'h0000_1000);
        mem[1] = ins(7'h04, 8'h03, 16'h0, 32'h1234_56AB);
        mem[2] = ins(7'h05, 8'h03, 16'h0, 32'hDEAD_BEEF, 1'b1);
        mem[3] = ins(7'h08, 8'h5C, 16'h0, 32'h2000_0040);
        mem[4] = ins(7'h10, 8'h00, 16'h0, 32'h0, 1'b1);
        start('0);
        wait_halt();
        chk("R3 write count", nl, 3);
        chk("R3 ind8 addr", la[0], 32'h1000);
        chk("R3 ind8 data", ld[0], 32'hAB);
        chk("R3 ind8 width", lw[0], 0);
        chk("R2 ind32 with phase addr", la[1], 32'h1000);
        chk("R2 ind32 with phase data", ld[1], 32'hDEAD_BEEF);
        chk("R3 ind32 width", lw[1], 1);
        chk("R4 dir8 addr", la[2], 32'h2000_0040);
        chk("R4 dir8 data", ld[2], 32'h5C);
        chk("R4 dir8 width", lw[2], 0);
        chk("R2 stop with phase notify", nnote, 1);
        chk("R2 no fault", fault, 0);
    endtask

    task automatic t_wait_cyc();
        clear_mem();
        mem[0] = ins(7'h08, 8'h01, 16'h0, 32'h10);
        mem[1] = ins(7'h20, 8'h00, 16'h0, 32'd7);
        mem[2] = ins(7'h08, 8'h02, 16'h0, 32'h10);
        mem[3] = ins(7'h20, 8'h00, 16'h0, 32'd0);
        mem[4] = ins(7'h08, 8'h03, 16'h0, 32'h10);
        start('0);
        wait_halt();
        chk("R6 write count", nl, 3);
        chk("R6 gap wait 7", lc[1] - lc[0], 11);
        chk("R6 gap wait 0", lc[2] - lc[1], 4);
    endtask

    task automatic t_wait_ev();
        clear_mem();
        mem[0] = ins(7'h08, 8'h01, 16'h0, 32'h30);
        mem[1] = ins(7'h24, 8'h05, 16'h0, 32'h0);
        mem[2] = ins(7'h08, 8'h02, 16'h0, 32'h30);
        mem[3] = ins(7'h25, 8'h02, 16'h0, 32'h0000_0011);
        mem[4] = ins(7'h08, 8'h03, 16'h0, 32'h30);
        start('0);
        repeat (30) @(negedge clk);
        chk("R7 blocked on single event", nl, 1);
        ev_set[5] = 1'b1;
        @(negedge clk);
        ev_set = '0;
        repeat (10) @(negedge clk);
        chk("R7 released by event 5", nl, 2);
        ev_set[64] = 1'b1;
        @(negedge clk);
        ev_set = '0;
        repeat (20) @(negedge clk);
        chk("R7 group wait needs all events", nl, 2);
        ev_set[68] = 1'b1;
        @(negedge clk);
        ev_set = '0;
        wait_halt();
        chk("R7 group wait released", nl, 3);
        chk("R7 last write data", ld[2], 32'h3);
    endtask

    task automatic t_branch();
        logic [127:0] pre;
        clear_mem();
        mem[0]  = ins(7'h30, 8'h00, 16'd2, 32'h0);
        mem[1]  = ins(7'h08, 8'hEE, 16'h0, 32'h50);
        mem[2]  = ins(7'h34, 8'd9,  16'd4, 32'h0);
        mem[3]  = ins(7'h08, 8'hEF, 16'h0, 32'h50);
        mem[4]  = ins(7'h51, 8'd9,  16'h0, 32'h0);
        mem[5]  = ins(7'h34, 8'd9,  16'd7, 32'h0);
        mem[6]  = ins(7'h08, 8'h01, 16'h0, 32'h50);
        mem[7]  = ins(7'h50, 8'h00, 16'h0, 32'h0);
        mem[8]  = ins(7'h34, 8'd10, 16'd10, 32'h0);
        mem[9]  = ins(7'h08, 8'h02, 16'h0, 32'h50);
        pre = '0; pre[9] = 1'b1; pre[10] = 1'b1;
        start(pre);
        wait_halt();
        chk("R8 R11 write count", nl, 2);
        chk("R11 single clear falls through", ld[0], 32'h01);
        chk("R11 clear all falls through", ld[1], 32'h02);
        chk("R8 jump and taken event branch", fault, 0);
    endtask

    task automatic t_counter();
        int na, nb, nx;
        clear_mem();
        mem[0]  = ins(7'h40, 8'd2, 16'h0, 32'd3);
        mem[1]  = ins(7'h08, 8'hA0, 16'h0, 32'h60);
        mem[2]  = ins(7'h41, 8'd2, 16'h0, 32'h0);
        mem[3]  = ins(7'h39, 8'd2, 16'd1, 32'h0);
        mem[4]  = ins(7'h40, 8'd4, 16'h0, 32'd100);
        mem[5]  = ins(7'h08, 8'hB0, 16'h0, 32'h60);
        mem[6]  = ins(7'h41, 8'd4, 16'h0, 32'h0);
        mem[7]  = ins(7'h39, 8'd4, 16'd5, 32'h0);
        mem[8]  = ins(7'h41, 8'd4, 16'h0, 32'h0);
        mem[9]  = ins(7'h38, 8'd4, 16'd11, 32'h0);
        mem[10] = ins(7'h08, 8'hCC, 16'h0, 32'h60);
        mem[11] = ins(7'h40, 8'd5, 16'h0, 32'd0);
        mem[12] = ins(7'h38, 8'd5, 16'd14, 32'h0);
        mem[13] = ins(7'h08, 8'hCD, 16'h0, 32'h60);
        start('0);
        wait_halt();
        na = 0; nb = 0; nx = 0;
        for (int i = 0; i < nl; i++) begin
            if (ld[i] == 32'hA0) na++;
            else if (ld[i] == 32'hB0) nb++;
            else nx++;
        end
        chk("R9 loop of 3", na, 3);
        chk("R9 saturated load loops 16", nb, 1 << CNT_LOG2);
        chk("R10 decrement at zero stays zero", nx, 0);
        chk("R9 total writes", nl, 3 + (1 << CNT_LOG2));
    endtask

    task automatic t_fault();
        clear_mem();
        mem[0] = ins(7'h08, 8'h01, 16'h0, 32'h70);
        mem[1] = ins(7'h7F, 8'h00, 16'h0, 32'h0);
        mem[2] = ins(7'h08, 8'h02, 16'h0, 32'h70);
        start('0);
        wait_halt();
        repeat (4) @(negedge clk);
        chk("R12 fault", fault, 1);
        chk("R12 halted", halted, 1);
        chk("R12 no notify", nnote, 0);
        chk("R12 no later write", nl, 1);
        chk("R12 addr held", imem_addr, 1);
    endtask

    logic done = 1'b0;

    initial begin
        wait (cyc > 150000);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_writes();
        t_wait_cyc();
        t_wait_ev();
        t_branch();
        t_counter();
        t_fault();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule